// File: doc/BRIEF.md
# Multicast port flush scanner

This block walks an address lookup table held in a synchronous single-port RAM and strips a set of ports from every multicast address entry. A one-cycle start pulse samples a port mask, a VLAN id and an all-VLANs flag. The engine then visits the entries in ascending index order. For each one it reads the entry, decides what to do with it in a capture cycle, and writes the result back in a write cycle. A multicast entry left with no ports is turned into a free slot rather than stored with an empty port set.

Some entries are exempt and keep their contents. These are super multicast entries, the broadcast address, entries whose VLAN does not match the filter, and any entry that is not an address entry. The block is meant for the moment a port leaves a bridge or a VLAN, when the control path needs every multicast group to stop forwarding to it. Unicast handling and register decoding sit elsewhere.

Top module: `mcast_flush_walker`

## Requirements
- R1: Entry kind lives in bits 61:60 (0 free, 1 address, 2 VLAN, 3 VLAN-plus-address). Only kinds 1 and 3 are candidates. Entries of kinds 0 and 2 are never written.
- R2: With `all_vlan_i` high, every candidate is processed. With it low, a candidate whose VLAN id in bits 59:48 differs from `vlan_i` is not written.
- R3: A candidate whose multicast bit (bit 40) is clear is written back unchanged.
- R4: A multicast candidate whose super flag (bit 65) is set is not written.
- R5: A multicast entry whose address (bits 47:0) is all ones is written back unchanged.
- R6: The port mask sits at bits 66 and up, one bit per port. If it shares no bit with the flush mask, the entry is written back unchanged. Otherwise the flushed ports are cleared from it.
- R7: If clearing leaves no ports, the kind field is set to 0 (free), and all other bits, including the old mask, are kept.
- R8: Each entry takes three cycles: read request, capture, write. Indices run from 0 to DEPTH-1. Busy stays high from the cycle after start through a single-cycle done pulse, which comes 3*DEPTH+1 cycles after start is sampled. Busy falls on the next cycle.
- R9: A start pulse seen while busy is ignored. The mask and VLAN sampled at the first start apply to the whole walk, and the walk length is unchanged.
- R10: After reset the engine is idle, with busy, done, read and write all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| flush_mask_i | input | PORTS | Ports to remove |
| vlan_i | input | 12 | VLAN id filter |
| all_vlan_i | input | 1 | Ignore VLAN id, process every VLAN |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse after the last entry |
| mem_addr_o | output | AW | Table index |
| mem_rd_o | output | 1 | Read request, data valid next cycle |
| mem_rdata_i | input | EW | Read data |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | EW | Write data |

## Verification
The hardest situation to reach from the ports is a second start pulse that lands in the middle of a walk carrying a different mask. If that pulse were accepted, entries late in the table would be flushed with the wrong ports. The bench loads one identical multicast entry near each end of the table and pulses start with another mask about halfway through. Both entries must come out with the first mask applied, and the walk length must not change. A mixed table also places every exemption (super, broadcast, VLAN entry, unicast, disjoint mask, VLAN mismatch) side by side, and the bench records which indices received writes.

// File: rtl/mfw_pkg.sv
package mfw_pkg;
    localparam int KIND_LO   = 60;
    localparam int VID_LO    = 48;
    localparam int VID_W     = 12;
    localparam int MAC_W     = 48;
    localparam int GROUP_BIT = 40;
    localparam int SUPER_BIT = 65;
    localparam int PMASK_LO  = 66;

    typedef enum logic [1:0] {
        KIND_FREE  = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_VLAN  = 2'd2,
        KIND_VADDR = 2'd3
    } ekind_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_CAP  = 3'd2,
        ST_WR   = 3'd3,
        ST_FIN  = 3'd4
    } wstate_t;
endpackage

// File: rtl/mfw_entry_eval.sv
module mfw_entry_eval
    import mfw_pkg::*;
#(
    parameter int PORTS = 6,
    parameter int EW    = PMASK_LO + PORTS
) (
    input  logic [EW-1:0]    ent_i,
    input  logic [PORTS-1:0] mask_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic             allv_i,
    output logic             wr_en_o,
    output logic [EW-1:0]    ent_o
);
    ekind_t           kind;
    logic             cand;
    logic             vhit;
    logic             grp;
    logic             sup;
    logic             bcast;
    logic [PORTS-1:0] pm;
    logic [PORTS-1:0] left;

    always_comb begin
        kind  = ekind_t'(ent_i[KIND_LO +: 2]);
        cand  = (kind == KIND_ADDR) || (kind == KIND_VADDR);
        vhit  = allv_i || (ent_i[VID_LO +: VID_W] == vid_i);
        grp   = ent_i[GROUP_BIT];
        sup   = ent_i[SUPER_BIT];
        bcast = &ent_i[MAC_W-1:0];
        pm    = ent_i[PMASK_LO +: PORTS];
        left  = pm & ~mask_i;

        wr_en_o = cand && vhit && !(grp && sup);
        ent_o   = ent_i;
        if (grp && !sup && !bcast && (|(pm & mask_i))) begin
            if (|left) begin
                ent_o[PMASK_LO +: PORTS] = left;
            end else begin
                ent_o[KIND_LO +: 2] = KIND_FREE;
            end
        end
    end
endmodule

// File: rtl/mfw_walk_ctrl.sv
module mfw_walk_ctrl
    import mfw_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PORTS = 6,
    parameter int EW    = PMASK_LO + PORTS,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PORTS-1:0] mask_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic             allv_i,
    input  logic [EW-1:0]    rdata_i,
    output logic [AW-1:0]    idx_o,
    output logic             rd_o,
    output logic             wr_phase_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [EW-1:0]    ent_o,
    output logic [PORTS-1:0] mask_o,
    output logic [VID_W-1:0] vid_o,
    output logic             allv_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        wstate_t          st;
        logic [AW-1:0]    idx;
        logic [PORTS-1:0] mask;
        logic [VID_W-1:0] vid;
        logic             allv;
        logic [EW-1:0]    ent;
    } walk_t;

    walk_t walk_d;
    walk_t walk_q;

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    walk_d.st   = ST_RD;
                    walk_d.idx  = '0;
                    walk_d.mask = mask_i;
                    walk_d.vid  = vid_i;
                    walk_d.allv = allv_i;
                end
            end
            ST_RD:  walk_d.st = ST_CAP;
            ST_CAP: begin
                walk_d.ent = rdata_i;
                walk_d.st  = ST_WR;
            end
            ST_WR: begin
                if (walk_q.idx == LAST) begin
                    walk_d.st = ST_FIN;
                end else begin
                    walk_d.idx = walk_q.idx + 1'b1;
                    walk_d.st  = ST_RD;
                end
            end
            ST_FIN:  walk_d.st = ST_IDLE;
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q    <= '0;
            walk_q.st <= ST_IDLE;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign idx_o      = walk_q.idx;
    assign rd_o       = (walk_q.st == ST_RD);
    assign wr_phase_o = (walk_q.st == ST_WR);
    assign busy_o     = (walk_q.st != ST_IDLE);
    assign done_o     = (walk_q.st == ST_FIN);
    assign ent_o      = walk_q.ent;
    assign mask_o     = walk_q.mask;
    assign vid_o      = walk_q.vid;
    assign allv_o     = walk_q.allv;
endmodule

// File: rtl/mcast_flush_walker.sv
module mcast_flush_walker
    import mfw_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PORTS = 6,
    parameter int EW    = PMASK_LO + PORTS,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PORTS-1:0] flush_mask_i,
    input  logic [VID_W-1:0] vlan_i,
    input  logic             all_vlan_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic             mem_rd_o,
    input  logic [EW-1:0]    mem_rdata_i,
    output logic             mem_wr_o,
    output logic [EW-1:0]    mem_wdata_o
);
    logic             wr_phase;
    logic [EW-1:0]    held_ent;
    logic [PORTS-1:0] held_mask;
    logic [VID_W-1:0] held_vid;
    logic             held_allv;
    logic             eval_wr;

    mfw_walk_ctrl #(
        .DEPTH(DEPTH), .PORTS(PORTS), .EW(EW), .AW(AW)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mask_i     (flush_mask_i),
        .vid_i      (vlan_i),
        .allv_i     (all_vlan_i),
        .rdata_i    (mem_rdata_i),
        .idx_o      (mem_addr_o),
        .rd_o       (mem_rd_o),
        .wr_phase_o (wr_phase),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .ent_o      (held_ent),
        .mask_o     (held_mask),
        .vid_o      (held_vid),
        .allv_o     (held_allv)
    );

    mfw_entry_eval #(
        .PORTS(PORTS), .EW(EW)
    ) eval_i (
        .ent_i   (held_ent),
        .mask_i  (held_mask),
        .vid_i   (held_vid),
        .allv_i  (held_allv),
        .wr_en_o (eval_wr),
        .ent_o   (mem_wdata_o)
    );

    assign mem_wr_o = wr_phase && eval_wr;
endmodule

// File: rtl/mfw_checker.sv
module mfw_checker
    import mfw_pkg::*;
#(
    parameter int PORTS = 6,
    parameter int EW    = PMASK_LO + PORTS,
    parameter int AW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             mem_rd_o,
    input logic             mem_wr_o,
    input logic [AW-1:0]    mem_addr_o,
    input logic [EW-1:0]    mem_wdata_o,
    input logic [PORTS-1:0] held_mask
);
    // R8
    rd_wr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    // R8
    addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> $stable(mem_addr_o));

    // R8
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> $past(mem_rd_o, 2));

    // R8
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o && !done_o);

    // R1
    kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (mem_wdata_o[KIND_LO +: 2] != KIND_VLAN));

    // R4
    no_super_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> !(mem_wdata_o[GROUP_BIT] && mem_wdata_o[SUPER_BIT]));

    // R6
    ports_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && mem_wdata_o[GROUP_BIT] && !(&mem_wdata_o[MAC_W-1:0])
         && (mem_wdata_o[KIND_LO +: 2] != KIND_FREE))
        |-> ((mem_wdata_o[PMASK_LO +: PORTS] & held_mask) == '0));

    // R9
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o && $stable(held_mask));
endmodule

bind mcast_flush_walker mfw_checker #(.PORTS(PORTS), .EW(EW), .AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .held_mask   (held_mask)
);

// File: tb/mcast_flush_walker_tb_top.sv
module mcast_flush_walker_tb_top;
    localparam int DEPTH = 64;
    localparam int P     = 6;
    localparam int EW    = 72;
    localparam int AW    = 6;
    localparam int WALK  = 3 * DEPTH + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [P-1:0]  flush_mask_i = '0;
    logic [11:0]   vlan_i = '0;
    logic          all_vlan_i = 1'b0;
    logic          busy_o, done_o, mem_rd_o, mem_wr_o;
    logic [AW-1:0] mem_addr_o;
    logic [EW-1:0] mem_rdata_i, mem_wdata_o;

    logic [EW-1:0] mem [DEPTH];
    bit            wr_seen [DEPTH];
    int            wr_cnt;
    int            last_wr;
    bit            order_bad;
    int            errors = 0;
    int            checks = 0;

    always #10 clk = ~clk;

    mcast_flush_walker #(.DEPTH(DEPTH), .PORTS(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .flush_mask_i(flush_mask_i), .vlan_i(vlan_i), .all_vlan_i(all_vlan_i),
        .busy_o(busy_o), .done_o(done_o), .mem_addr_o(mem_addr_o),
        .mem_rd_o(mem_rd_o), .mem_rdata_i(mem_rdata_i),
        .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o)
    );

    always @(posedge clk) begin
        if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
        if (mem_wr_o) begin
            mem[mem_addr_o] <= mem_wdata_o;
            wr_seen[mem_addr_o] = 1'b1;
            wr_cnt = wr_cnt + 1;
            if (int'(mem_addr_o) <= last_wr) order_bad = 1'b1;
            last_wr = int'(mem_addr_o);
        end
    end

    function automatic logic [EW-1:0] mk(input logic [1:0] k, input logic [11:0] v,
                                         input logic [47:0] a, input logic s,
                                         input logic [P-1:0] m);
        logic [EW-1:0] e;
        e = '0;
        e[61:60] = k;
        e[59:48] = v;
        e[47:0]  = a;
        e[65]    = s;
        e[71:66] = m;
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [79:0] act,
                       input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_table();
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = '0;
            wr_seen[i] = 1'b0;
        end
        wr_cnt = 0;
        last_wr = -1;
        order_bad = 1'b0;
    endtask

    task automatic run_flush(input logic [P-1:0] m, input logic [11:0] v,
                             input bit allv, input int mid_at,
                             input logic [P-1:0] mid_m, output int cyc);
        @(negedge clk);
        flush_mask_i = m; vlan_i = v; all_vlan_i = allv; start_i = 1'b1;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            start_i = (cyc == mid_at);
            if (cyc == mid_at) flush_mask_i = mid_m;
            if (done_o) break;
            if (cyc > 4 * WALK) begin
                chk(1'b0, "R8 watchdog", 80'(cyc), 80'(WALK));
                break;
            end
        end
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R8 busy with done", 80'(busy_o), 80'd1);
        @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R8 idle after done",
            80'({busy_o, done_o}), 80'd0);
    endtask

    task automatic t_reset();
        chk({busy_o, done_o, mem_rd_o, mem_wr_o} == 4'b0, "R10 reset outputs",
            80'({busy_o, done_o, mem_rd_o, mem_wr_o}), 80'd0);
    endtask

    task automatic t_mixed();
        logic [EW-1:0] e2, e3, e4, e5, e6, e7, e8;
        int cyc;
        clear_table();
        e2 = mk(2'd1, 12'd5, 48'h01005E000001, 1'b0, 6'b000111);
        e3 = mk(2'd1, 12'd5, 48'h01005E000002, 1'b0, 6'b000011);
        e4 = mk(2'd1, 12'd7, 48'h01005E000003, 1'b0, 6'b110000);
        e5 = mk(2'd1, 12'd5, 48'h020000000001, 1'b0, 6'b000011);
        e6 = mk(2'd1, 12'd5, 48'h01005E000004, 1'b1, 6'b000011);
        e7 = mk(2'd1, 12'd5, 48'hFFFFFFFFFFFF, 1'b0, 6'b000011);
        e8 = mk(2'd2, 12'd5, 48'h01005E000005, 1'b0, 6'b000011);
        mem[2] = e2; mem[3] = e3; mem[4] = e4; mem[5] = e5;
        mem[6] = e6; mem[7] = e7; mem[8] = e8;
        run_flush(6'b000011, 12'd0, 1'b1, -1, 6'b0, cyc);
        chk(cyc == WALK, "R8 walk length", 80'(cyc), 80'(WALK));
        chk(mem[2] == mk(2'd1, 12'd5, 48'h01005E000001, 1'b0, 6'b000100),
            "R6 ports cleared", 80'(mem[2]), 80'(mk(2'd1, 12'd5, 48'h01005E000001, 1'b0, 6'b000100)));
        chk(mem[3] == mk(2'd0, 12'd5, 48'h01005E000002, 1'b0, 6'b000011),
            "R7 emptied entry freed", 80'(mem[3]), 80'(mk(2'd0, 12'd5, 48'h01005E000002, 1'b0, 6'b000011)));
        chk(mem[4] == e4 && wr_seen[4], "R6 disjoint unchanged", 80'(mem[4]), 80'(e4));
        chk(mem[5] == e5 && wr_seen[5], "R3 unicast rewritten unchanged", 80'(mem[5]), 80'(e5));
        chk(mem[6] == e6 && !wr_seen[6], "R4 super not written", 80'(wr_seen[6]), 80'd0);
        chk(mem[7] == e7 && wr_seen[7], "R5 broadcast unchanged", 80'(mem[7]), 80'(e7));
        chk(mem[8] == e8 && !wr_seen[8], "R1 VLAN entry not written", 80'(wr_seen[8]), 80'd0);
        chk(!wr_seen[0], "R1 free entry not written", 80'(wr_seen[0]), 80'd0);
        chk(wr_cnt == 5, "R1 write count", 80'(wr_cnt), 80'd5);
        chk(!order_bad, "R8 ascending order", 80'(order_bad), 80'd0);
    endtask

    task automatic t_vlan();
        logic [EW-1:0] a, b;
        int cyc;
        clear_table();
        a = mk(2'd3, 12'd5, 48'h01005E000010, 1'b0, 6'b000011);
        b = mk(2'd3, 12'd9, 48'h01005E000011, 1'b0, 6'b000011);
        mem[10] = a; mem[11] = b;
        run_flush(6'b000001, 12'd5, 1'b0, -1, 6'b0, cyc);
        chk(mem[10] == mk(2'd3, 12'd5, 48'h01005E000010, 1'b0, 6'b000010),
            "R2 matching VLAN flushed", 80'(mem[10]), 80'(mk(2'd3, 12'd5, 48'h01005E000010, 1'b0, 6'b000010)));
        chk(mem[11] == b && !wr_seen[11], "R2 other VLAN not written", 80'(mem[11]), 80'(b));
        chk(wr_cnt == 1, "R2 write count", 80'(wr_cnt), 80'd1);
    endtask

    task automatic t_restart();
        logic [EW-1:0] exp;
        int cyc;
        clear_table();
        mem[1]  = mk(2'd1, 12'd3, 48'h01005E000020, 1'b0, 6'b000011);
        mem[60] = mk(2'd1, 12'd3, 48'h01005E000021, 1'b0, 6'b000011);
        run_flush(6'b000001, 12'd0, 1'b1, 90, 6'b000010, cyc);
        chk(cyc == WALK, "R9 walk length unchanged", 80'(cyc), 80'(WALK));
        exp = mk(2'd1, 12'd3, 48'h01005E000020, 1'b0, 6'b000010);
        chk(mem[1] == exp, "R9 early entry first mask", 80'(mem[1]), 80'(exp));
        exp = mk(2'd1, 12'd3, 48'h01005E000021, 1'b0, 6'b000010);
        chk(mem[60] == exp, "R9 late entry first mask", 80'(mem[60]), 80'(exp));
    endtask

    initial begin
        clear_table();
        mem_rdata_i = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mixed();
        t_vlan();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule